// File: doc/BRIEF.md
# UID CRC-8 checker

This block checks a 9-byte identity record that arrives one byte per cycle on a valid/ready stream. The first byte of each record is a stored checksum. The next eight bytes are a 64-bit unique identifier.

While the identifier bytes stream in, the block runs an 8-bit CRC over them, one whole byte per cycle. It also places each byte into its slot of a little-endian identifier word. When the last byte is accepted, the block compares the computed CRC with the leading checksum byte. It then publishes three results:

- the assembled identifier;
- a match flag;
- a one-cycle completion pulse.

On a mismatch it raises an error pulse and holds the identifier-valid flag low. A clear input abandons any partial record, so the next accepted byte is taken as a fresh checksum byte.

Top module: `uid_crc_check`

## Requirements
- R1: After reset, `done`, `match`, `crc_err` and `id_valid` are 0, `id_out` is all zeros and `in_ready` is 1.
- R2: The CRC uses generator 0x07, starts at 0xFF, takes each byte MSB first and applies no final inversion. It covers only record bytes 1 to 8. `match` is 1 exactly when that CRC equals record byte 0.
- R3: `id_out` holds record byte 1 in bits 7:0, byte 2 in bits 15:8, and so on up to byte 8 in bits 63:56.
- R4: `done` is high for exactly one cycle, in the cycle after the ninth byte of a record is accepted. `id_out`, `match`, `crc_err` and `id_valid` take their new values in that same cycle.
- R5: On a CRC mismatch, `crc_err` pulses together with `done`, `match` is 0 and `id_valid` stays 0.
- R6: `id_valid` rises together with `done` when a record matches. It stays high until `clr` is asserted or the first byte of the next record is accepted.
- R7: While `clr` is high, `in_ready` is 0 and offered bytes are dropped. After `clr`, the next accepted byte is treated as byte 0 of a new record and the CRC restarts from 0xFF.
- R8: Cycles with `in_valid` low neither advance the record nor change the CRC, so gaps between bytes leave the result unchanged.
- R9: Records may follow back to back. The byte accepted right after a record's ninth byte is byte 0 of the next record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Abandon the partial record and restart the CRC |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | 8 | Record byte |
| in_ready | output | 1 | The block accepts a byte this cycle |
| id_out | output | 64 | Identifier from the last completed record, little-endian |
| match | output | 1 | The last completed record's CRC matched |
| crc_err | output | 1 | One-cycle pulse on a completed record whose CRC mismatched |
| id_valid | output | 1 | `id_out` is a checked, trusted identifier |
| done | output | 1 | One-cycle record-completion pulse |

## Verification
The bench builds the block with its default of eight identifier bytes. This exercises the widest identifier word, every byte slot of the assembler, and the record counter's top index and its wrap into the next record. Records are sent with and without idle gaps, back to back, with all-zero and all-ones identifiers, with a corrupted checksum, and across a clear that arrives mid-record. The expected CRC is recomputed in the bench with a bit-serial form, and the expected results are queued in a scoreboard.

// File: rtl/uidc_pkg.sv
package uidc_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [7:0]  CRC_POLY = 8'h07;
    localparam logic [7:0]  CRC_INIT = 8'hFF;

    typedef logic [BYTE_W-1:0] byte_t;

    // Outcome of one completed record
    typedef struct packed {
        logic fin;
        logic ok;
    } verdict_t;

    // One byte folded into the CRC: xor in, then eight shift steps
    function automatic byte_t crc8_byte(input byte_t crc, input byte_t data);
        byte_t v;
        v = crc ^ data;
        for (int k = 0; k < BYTE_W; k++) begin
            if (v[BYTE_W-1]) v = (v << 1) ^ CRC_POLY;
            else             v = v << 1;
        end
        return v;
    endfunction

endpackage

// File: rtl/uidc_seq.sv
module uidc_seq #(
    parameter int ID_BYTES = 8,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             accept,
    output logic             hdr_acc,
    output logic             fin_acc,
    output logic [CNT_W-1:0] idx,
    output logic             done
);

    logic [CNT_W-1:0] idx_q;
    logic             done_q;
    logic             at_hdr;
    logic             at_last;

    assign in_ready = ~clr;
    assign accept   = in_valid & in_ready;
    assign at_hdr   = (idx_q == '0);
    assign at_last  = (idx_q == CNT_W'(ID_BYTES));
    assign hdr_acc  = accept & at_hdr;
    assign fin_acc  = accept & at_last;
    assign idx      = idx_q;
    assign done     = done_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= at_last ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= fin_acc;
    end

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R4
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(accept && at_last));

    // R7
    clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (idx_q == '0));

    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q <= CNT_W'(ID_BYTES));

endmodule

// File: rtl/uidc_crc_unit.sv
module uidc_crc_unit
    import uidc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  load_hdr,
    input  logic  step_en,
    input  byte_t din,
    output byte_t crc_next
);

    byte_t crc_q;

    assign crc_next = crc8_byte(crc_q, din);

    always_ff @(posedge clk) begin
        if (rst || clr || load_hdr) begin
            crc_q <= CRC_INIT;
        end else if (step_en) begin
            crc_q <= crc_next;
        end
    end

    // R8
    crc_hold_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (!step_en && !load_hdr) |=> $stable(crc_q));

endmodule

// File: rtl/uidc_id_asm.sv
module uidc_id_asm
    import uidc_pkg::*;
#(
    parameter int ID_BYTES = 8,
    parameter int CNT_W    = 4,
    localparam int ID_W    = ID_BYTES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] idx,
    input  byte_t            din,
    output logic [ID_W-1:0]  id_next
);

    logic [ID_W-1:0] id_q;

    for (genvar g = 0; g < ID_BYTES; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (idx == CNT_W'(g + 1));
        assign id_next[g*BYTE_W +: BYTE_W] = hit ? din : id_q[g*BYTE_W +: BYTE_W];

        always_ff @(posedge clk) begin
            if (rst || clr) id_q[g*BYTE_W +: BYTE_W] <= '0;
            else if (hit)   id_q[g*BYTE_W +: BYTE_W] <= din;
        end
    end

endmodule

// File: rtl/uid_crc_check.sv
module uid_crc_check
    import uidc_pkg::*;
#(
    parameter int ID_BYTES = 8,
    localparam int ID_W    = ID_BYTES * BYTE_W,
    localparam int CNT_W   = $clog2(ID_BYTES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    output logic            in_ready,
    output logic [ID_W-1:0] id_out,
    output logic            match,
    output logic            crc_err,
    output logic            id_valid,
    output logic            done
);

    logic             accept;
    logic             hdr_acc;
    logic             fin_acc;
    logic [CNT_W-1:0] idx;
    byte_t            crc_next;
    byte_t            expect_q;
    logic [ID_W-1:0]  id_next;
    logic [ID_W-1:0]  id_out_q;
    logic             match_q;
    logic             err_q;
    logic             valid_q;
    verdict_t         vd;

    uidc_seq #(.ID_BYTES(ID_BYTES), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .in_ready(in_ready), .accept(accept), .hdr_acc(hdr_acc),
        .fin_acc(fin_acc), .idx(idx), .done(done)
    );

    uidc_crc_unit u_crc (
        .clk(clk), .rst(rst), .clr(clr), .load_hdr(hdr_acc),
        .step_en(accept && !hdr_acc), .din(in_data), .crc_next(crc_next)
    );

    uidc_id_asm #(.ID_BYTES(ID_BYTES), .CNT_W(CNT_W)) u_asm (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(accept), .idx(idx),
        .din(in_data), .id_next(id_next)
    );

    assign vd.fin = fin_acc;
    assign vd.ok  = (crc_next == expect_q);

    always_ff @(posedge clk) begin
        if (rst) expect_q <= '0;
        else if (hdr_acc) expect_q <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_out_q <= '0;
            match_q  <= 1'b0;
            err_q    <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            err_q <= vd.fin && !vd.ok;
            if (vd.fin) begin
                id_out_q <= id_next;
                match_q  <= vd.ok;
                valid_q  <= vd.ok;
            end else if (clr || hdr_acc) begin
                valid_q  <= 1'b0;
            end
        end
    end

    assign id_out   = id_out_q;
    assign match    = match_q;
    assign crc_err  = err_q;
    assign id_valid = valid_q;

    // R5
    err_done_chk: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> (done && !match && !id_valid));

    // R6
    valid_match_chk: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> match);

    // R6
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(id_valid) |-> done);

endmodule

// File: tb/sim_uid_crc_check.sv
`timescale 1ns/1ps
module sim_uid_crc_check;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic [63:0] id_out;
    logic        match;
    logic        crc_err;
    logic        id_valid;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [63:0] q_id[$];
    bit          q_ok[$];

    always #(CLK_NS / 2.0) clk = ~clk;

    uid_crc_check u0 (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .id_out(id_out),
        .match(match), .crc_err(crc_err), .id_valid(id_valid), .done(done)
    );

    // Bit-serial CRC over the identifier bytes, byte 1 first
    function automatic logic [7:0] exp_crc(input logic [63:0] id);
        logic [7:0] c = 8'hFF;
        for (int b = 0; b < 8; b++) begin
            for (int k = 7; k >= 0; k--) begin
                logic fb;
                fb = c[7] ^ id[b*8 + k];
                c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic send_rec(input logic [63:0] id, input bit bad, input int gap);
        logic [7:0] c;
        c = exp_crc(id);
        if (bad) c = c ^ 8'h5A;
        q_id.push_back(id);
        q_ok.push_back(!bad);
        send_byte(c, gap);
        for (int b = 0; b < 8; b++) send_byte(id[b*8 +: 8], gap);
    endtask

    // Scoreboard monitor
    bit prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done && done) check("R4 done width", 64'(done), 64'd0);
            if (done) begin
                if (q_id.size() == 0) begin
                    check("R4 unexpected done", 64'd1, 64'd0);
                end else begin
                    logic [63:0] eid;
                    bit          eok;
                    eid = q_id.pop_front();
                    eok = q_ok.pop_front();
                    check("R3 id_out", id_out, eid);
                    check("R2 match", 64'(match), 64'(eok));
                    check("R5 crc_err", 64'(crc_err), 64'(!eok));
                    check("R6 id_valid", 64'(id_valid), 64'(eok));
                end
            end
            prev_done = done;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 done", 64'(done), 64'd0);
        check("R1 match", 64'(match), 64'd0);
        check("R1 crc_err", 64'(crc_err), 64'd0);
        check("R1 id_valid", 64'(id_valid), 64'd0);
        check("R1 id_out", id_out, 64'd0);
        check("R1 in_ready", 64'(in_ready), 64'd1);

        // R2 R3 good record
        send_rec(64'h8877_6655_4433_2211, 1'b0, 0);
        idle(4);
        // R5 bad checksum
        send_rec(64'h0123_4567_89AB_CDEF, 1'b1, 0);
        idle(3);
        // R8 gaps between bytes
        send_rec(64'hDEAD_BEEF_CAFE_F00D, 1'b0, 2);
        idle(3);
        // R9 back to back
        send_rec(64'h1111_2222_3333_4444, 1'b0, 0);
        send_rec(64'h5555_6666_7777_8888, 1'b1, 0);
        send_rec(64'h9999_AAAA_BBBB_CCCC, 1'b0, 0);
        idle(3);
        // R2 corner identifiers
        send_rec(64'h0, 1'b0, 0);
        idle(2);
        send_rec(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1);
        idle(5);

        // R6 id_valid held, then dropped by next header byte
        check("R6 id_valid held", 64'(id_valid), 64'd1);
        send_byte(8'h3C, 0);
        idle(1);
        check("R6 id_valid after header", 64'(id_valid), 64'd0);

        // R7 clear abandons partial record, bytes during clr dropped
        send_byte(8'h01, 0);
        send_byte(8'h02, 0);
        @(negedge clk);
        clr = 1'b1;
        in_valid = 1'b1;
        in_data = 8'hA5;
        @(negedge clk);
        check("R7 in_ready during clr", 64'(in_ready), 64'd0);
        @(negedge clk);
        clr = 1'b0;
        in_valid = 1'b0;
        send_rec(64'h0F1E_2D3C_4B5A_6978, 1'b0, 0);
        idle(3);

        // R7 clr drops id_valid
        check("R7 id_valid before clr", 64'(id_valid), 64'd1);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R6 id_valid after clr", 64'(id_valid), 64'd0);
        check("R3 id_out held across clr", id_out, 64'h0F1E_2D3C_4B5A_6978);

        idle(4);
        check("R4 scoreboard drained", 64'(q_id.size()), 64'd0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule